// File: doc/BRIEF.md
# One-Hot Parallel Multiplexer with Default Word

This block is a purely combinational selector. It picks one of `S_WIDTH` data words, all packed side by side into one wide case input, using a one-hot pick vector. A separate default word goes to the output whenever the pick vector is all zeros. It implements the hardware of a parallel case statement: the case arms are mutually exclusive, so no arm takes priority over another.

The output is built as an AND-OR plane. Each case slice is gated by its own pick bit, the default word is gated by "no pick bit set", and the gated words are ORed together. A pick vector with two or more bits set has no defined data result. The block raises a status flag for that condition and does not resolve it by priority.

When the block is built with a single pick bit, it becomes a plain two-way selector.

Top module: `onehot_par_mux`

## Requirements
- R1: Case slice n occupies bits `[n*WIDTH +: WIDTH]` of `cases_i`, so slice 0 sits at the least significant end. `dflt_i` and `word_o` are WIDTH bits wide, and `pick_i` is S_WIDTH bits wide.
- R2: When every bit of `pick_i` is 0, `word_o` equals `dflt_i`.
- R3: When exactly one bit n of `pick_i` is 1, `word_o` equals case slice n.
- R4: `multi_hot_o` is 1 exactly when two or more bits of `pick_i` are 1.
- R5: `multi_hot_o` is 0 for an all-zero pick vector and for any pick vector with a single bit set.
- R6: With S_WIDTH equal to 1, `word_o` is `cases_i` when `pick_i` is 1 and `dflt_i` when `pick_i` is 0, and `multi_hot_o` stays 0.
- R7: The block holds no state. `word_o` and `multi_hot_o` follow a change of the inputs without waiting for a clock edge.
- R8: While a pick bit is set, changes on `dflt_i` have no effect on `word_o`.
- R9: While exactly one pick bit is set, changes on the case slices that are not picked have no effect on `word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dflt_i | input | WIDTH | Default word, passed through when no pick bit is set |
| cases_i | input | WIDTH*S_WIDTH | Packed case words, slice 0 at the least significant end |
| pick_i | input | S_WIDTH | One-hot pick vector, one bit per case slice |
| word_o | output | WIDTH | Selected word; undefined while `multi_hot_o` is 1 |
| multi_hot_o | output | 1 | High when two or more pick bits are set |

## Verification
The bench builds two instances. The first uses WIDTH 8 and S_WIDTH 5. This is wide enough to walk every single-bit pick, every pair of pick bits, the all-ones vector and a few sparse multi-bit patterns, and to place five distinct bytes so that a slice that is shifted or misaligned is visible. The second uses S_WIDTH 1, which brings the two-way variant within reach. The data output is compared only when the flag is low. The flag itself is compared against a population count of the pick vector.

// File: rtl/ohm_pkg.sv
// Shared types for the one-hot parallel multiplexer.
// Assumes: consumers import the package; no state is held here.
package ohm_pkg;

    // Classification of a pick vector by how many bits are set.
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_ONE  = 2'd1,
        PICK_MANY = 2'd2
    } pick_class_e;

endpackage

// File: rtl/ohm_pick_classify.sv
// Classifies a pick vector as empty, single-hot or multi-hot.
// Assumes: S_WIDTH >= 1. Pairwise AND terms are used, so no
// priority chain and no counter appear in the logic.
module ohm_pick_classify
    import ohm_pkg::*;
#(
    parameter int S_WIDTH = 4
) (
    input  logic [S_WIDTH-1:0] pick_i,
    output pick_class_e        class_o
);

    logic        any_set;
    logic        many_set;
    pick_class_e cls;

    // Purpose: detect any set bit and any set pair, then classify.
    always_comb begin
        any_set  = 1'b0;
        many_set = 1'b0;
        for (int i = 0; i < S_WIDTH; i++) begin
            any_set = any_set | pick_i[i];
            for (int j = i + 1; j < S_WIDTH; j++) begin
                many_set = many_set | (pick_i[i] & pick_i[j]);
            end
        end
        if (many_set)     cls = PICK_MANY;
        else if (any_set) cls = PICK_ONE;
        else              cls = PICK_NONE;
        class_o = cls;

        AST_MANY_IFF_TWO_SET: assert ((cls == PICK_MANY) == ($countones(pick_i) > 1)); // R4
        AST_NONE_IFF_ZERO:    assert ((cls == PICK_NONE) == (pick_i == '0));           // R5
    end

endmodule

// File: rtl/ohm_and_or_plane.sv
// AND-OR data plane. Each case slice is gated by its pick bit, the
// default word is gated by "no pick set", and the gated words are ORed.
// Assumes: at most one pick bit is set when the result is used.
module ohm_and_or_plane #(
    parameter int WIDTH   = 8,
    parameter int S_WIDTH = 4
) (
    input  logic [WIDTH-1:0]         dflt_i,
    input  logic [WIDTH*S_WIDTH-1:0] cases_i,
    input  logic [S_WIDTH-1:0]       pick_i,
    output logic [WIDTH-1:0]         word_o
);

    logic [WIDTH-1:0] acc;

    // Purpose: form the OR of the gated slices and the gated default.
    always_comb begin
        acc = dflt_i & {WIDTH{~|pick_i}};
        for (int n = 0; n < S_WIDTH; n++) begin
            acc = acc | (cases_i[n*WIDTH +: WIDTH] & {WIDTH{pick_i[n]}});
        end
        word_o = acc;

        if (pick_i == '0) begin
            AST_ZERO_PICK_GIVES_DFLT: assert (acc == dflt_i); // R2
        end
        for (int n = 0; n < S_WIDTH; n++) begin
            if (pick_i == (S_WIDTH'(1) << n)) begin
                AST_SINGLE_PICK_GIVES_SLICE: assert (acc == cases_i[n*WIDTH +: WIDTH]); // R3
            end
        end
    end

endmodule

// File: rtl/onehot_par_mux.sv
// One-hot parallel multiplexer with a default word and a multi-hot flag.
// Assumes: purely combinational use. word_o is meaningful only while
// multi_hot_o is low. S_WIDTH == 1 selects a plain two-way variant.
module onehot_par_mux
    import ohm_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int S_WIDTH = 4
) (
    input  logic [WIDTH-1:0]           dflt_i,
    input  logic [WIDTH*S_WIDTH-1:0]   cases_i,
    input  logic [S_WIDTH-1:0]         pick_i,
    output logic [WIDTH-1:0]           word_o,
    output logic                       multi_hot_o
);

    localparam int CASE_BITS = WIDTH * S_WIDTH;

    generate
        if (S_WIDTH == 1) begin : g_two_way
            // Purpose: a single pick bit reduces to a 2:1 selector.
            always_comb begin
                word_o      = pick_i[0] ? cases_i[CASE_BITS-1:0] : dflt_i;
                multi_hot_o = 1'b0;
            end
        end else begin : g_plane
            pick_class_e cls;

            ohm_pick_classify #(
                .S_WIDTH (S_WIDTH)
            ) classify_i (
                .pick_i  (pick_i),
                .class_o (cls)
            );

            ohm_and_or_plane #(
                .WIDTH   (WIDTH),
                .S_WIDTH (S_WIDTH)
            ) plane_i (
                .dflt_i  (dflt_i),
                .cases_i (cases_i),
                .pick_i  (pick_i),
                .word_o  (word_o)
            );

            // Purpose: raise the flag for an undefined (multi-hot) pick.
            always_comb begin
                multi_hot_o = (cls == PICK_MANY);
            end
        end
    endgenerate

endmodule

// File: tb/onehot_par_mux_tb_top.sv
module onehot_par_mux_tb_top;

    localparam int TW = 8;
    localparam int TS = 5;
    localparam int NV = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic [TW-1:0]    dflt  = '0;
    logic [TW*TS-1:0] cases = '0;
    logic [TS-1:0]    pick  = '0;
    logic [TW-1:0]    word;
    logic             multi;

    logic [TW-1:0] n_dflt  = '0;
    logic [TW-1:0] n_cases = '0;
    logic [0:0]    n_pick  = '0;
    logic [TW-1:0] n_word;
    logic          n_multi;

    onehot_par_mux #(.WIDTH(TW), .S_WIDTH(TS)) dut_i (
        .dflt_i(dflt), .cases_i(cases), .pick_i(pick),
        .word_o(word), .multi_hot_o(multi));

    onehot_par_mux #(.WIDTH(TW), .S_WIDTH(1)) dut1_i (
        .dflt_i(n_dflt), .cases_i(n_cases), .pick_i(n_pick),
        .word_o(n_word), .multi_hot_o(n_multi));

    localparam logic [TS-1:0] V_PICK [NV] = '{
        5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01000,
        5'b10000, 5'b00011, 5'b10001, 5'b11111, 5'b01010};
    localparam logic [TW-1:0] V_DFLT [NV] = '{
        8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81,
        8'h7E, 8'h55, 8'hC3, 8'h18, 8'hE7};
    localparam logic [TW*TS-1:0] V_CASES [NV] = '{
        40'h55_44_33_22_11, 40'h01_02_04_08_10, 40'hF0_E1_D2_C3_B4,
        40'h9A_BC_DE_F0_12, 40'h00_FF_00_FF_00, 40'h6B_5A_49_38_27,
        40'h11_22_33_44_55, 40'h8E_7D_6C_5B_4A, 40'hAA_BB_CC_DD_EE,
        40'h13_57_9B_DF_02};

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pop(input logic [TS-1:0] p);
        int c = 0;
        for (int i = 0; i < TS; i++) c += int'(p[i]);
        return c;
    endfunction

    // Reference: default for no pick, indexed slice for a single pick.
    function automatic logic [TW-1:0] model(input logic [TW-1:0] d,
                                           input logic [TW*TS-1:0] c,
                                           input logic [TS-1:0] p);
        logic [TW-1:0] r = d;
        for (int i = 0; i < TS; i++) if (p[i]) r = c[i*TW +: TW];
        return r;
    endfunction

    task automatic apply(input logic [TW-1:0] d, input logic [TW*TS-1:0] c, input logic [TS-1:0] p);
        @(posedge clk);
        dflt = d; cases = c; pick = p;
        @(negedge clk);
    endtask

    initial begin
        // Idle state: all-zero inputs give a zero word and no flag.
        @(negedge clk);
        chk("R2 idle word", 64'(word), 64'(0));
        chk("R5 idle flag", 64'(multi), 64'(0));

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            apply(V_DFLT[v], V_CASES[v], V_PICK[v]);
            chk(pop(V_PICK[v]) > 1 ? "R4 table flag" : "R5 table flag",
                64'(multi), 64'(pop(V_PICK[v]) > 1));
            if (pop(V_PICK[v]) == 0)
                chk("R2 table word", 64'(word), 64'(V_DFLT[v]));
            else if (pop(V_PICK[v]) == 1)
                chk("R3 table word", 64'(word), 64'(model(V_DFLT[v], V_CASES[v], V_PICK[v])));
        end

        // R1: slice placement, slice 0 at the least significant end.
        for (int n = 0; n < TS; n++) begin
            apply(8'h00, 40'hE5_D4_C3_B2_A1, TS'(1) << n);
            chk("R1 slice position", 64'(word), 64'(8'hA1 + 8'(n) * 8'h11));
        end

        // R4: every pair of pick bits raises the flag.
        for (int i = 0; i < TS; i++) begin
            for (int j = i + 1; j < TS; j++) begin
                apply(8'h5A, 40'h0, (TS'(1) << i) | (TS'(1) << j));
                chk("R4 pair flag", 64'(multi), 64'(1));
            end
        end

        // R8: default ignored while a pick bit is set.
        for (int k = 0; k < 3; k++) begin
            apply(8'(k * 8'h47 + 8'h0F), 40'h10_20_30_40_50, 5'b00100);
            chk("R8 default ignored", 64'(word), 64'(8'h30));
        end

        // R9: unpicked slices ignored.
        apply(8'h99, 40'hFF_FF_6D_FF_FF, 5'b00100);
        chk("R9 other slices ignored", 64'(word), 64'(8'h6D));
        apply(8'h99, 40'h00_00_6D_00_00, 5'b00100);
        chk("R9 other slices ignored", 64'(word), 64'(8'h6D));

        // R7: output follows an input change between clock edges.
        @(posedge clk);
        #3 pick = 5'b01000;
        #1 chk("R7 combinational follow", 64'(word), 64'(8'h00));
        #1 pick = 5'b00000;
        #1 chk("R7 combinational follow", 64'(word), 64'(8'h99));

        // R6: single-pick-bit variant.
        @(posedge clk);
        n_dflt = 8'h3E; n_cases = 8'hC1; n_pick = 1'b0;
        @(negedge clk);
        chk("R6 two-way default", 64'(n_word), 64'(8'h3E));
        chk("R6 two-way flag", 64'(n_multi), 64'(0));
        @(posedge clk);
        n_pick = 1'b1;
        @(negedge clk);
        chk("R6 two-way case", 64'(n_word), 64'(8'hC1));
        chk("R6 two-way flag", 64'(n_multi), 64'(0));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule